// File: doc/BRIEF.md
# Constant Buffer Streaming Writer

This block converts a stream of register writes into sequential 32-bit memory stores that fill a constant buffer. Software programs a 64-bit buffer base as two 32-bit halves, a buffer size in bytes, and an optional starting byte position. It then pushes data words through any of a bank of sixteen aliased data registers. Each data word becomes one memory write request at base plus the current position, and the position then moves forward by one word.

Two checks guard every data word. A word is refused if the base address is still zero, or if storing it would run past the programmed size. A refused word produces no memory request and leaves the position where it was. It also sets an error bit, which stays set until software writes a 1 to the clear register. The memory side is a single valid/ready request port. While that port is applying back-pressure, the register port is held off, so no word is ever dropped.

Top module: `cbuf_stream_writer`

## Requirements
- R1: After reset the block presents no memory request, the error bit is clear, and base, size and position are all zero.
- R2: A write to any register index from 16 to 31 emits exactly one memory request whose data equals the written word.
- R3: The request address is the 64-bit base plus the current byte position. Index 0 holds the base bits 63:32 and index 1 holds the base bits 31:0.
- R4: Each accepted data word advances the byte position by 4.
- R5: A data word for which position + 4 exceeds the size (index 2) is refused: no request is made, the error bit is set, and the position is unchanged. A word for which position + 4 equals the size is accepted.
- R6: A data word written while the base is zero is refused and sets the error bit.
- R7: A write to index 3 loads the byte position, and that value applies to the very next data word.
- R8: While a request is held and the memory port is not ready, reg_wr_ready is low, and the request address and data stay stable.
- R9: The error bit is sticky. Only a write to index 4 with bit 0 set clears it; a write of 0 to that index leaves it unchanged.
- R10: A write to any index outside 16 to 31 never produces a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_valid | input | 1 | Register write offered |
| reg_wr_ready | output | 1 | Register write can be taken this cycle |
| reg_wr_idx | input | 6 | Register index |
| reg_wr_data | input | 32 | Register write value |
| mem_req_valid | output | 1 | Memory write request held |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_req_data | output | 32 | Word to store |
| err_flag | output | 1 | Sticky refusal flag |

## Verification
The assertions assume that the memory side never withdraws ready in a way that breaks a handshake. They also assume that a register write counts only on a cycle where both valid and ready are high; an offer left pending while ready is low is not treated as taken. The stimulus changes inputs only at the falling clock edge and keeps reg_wr_valid high until the write is taken. The memory ready line is driven either high or from a pseudo-random sequence, so stalls fall both on data words and on configuration writes.

// File: rtl/cbw_pkg.sv
// Package: shared widths and register index map for the constant buffer writer.
// Assumes byte-addressed memory and a word size that is a whole number of bytes.
package cbw_pkg;
    localparam int ADDR_W     = 64;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int IDX_W      = 6;

    // Configuration register indices (the block's own layout)
    localparam logic [IDX_W-1:0] IDX_BASE_HI = 6'd0;
    localparam logic [IDX_W-1:0] IDX_BASE_LO = 6'd1;
    localparam logic [IDX_W-1:0] IDX_SIZE    = 6'd2;
    localparam logic [IDX_W-1:0] IDX_POS     = 6'd3;
    localparam logic [IDX_W-1:0] IDX_ERR_CLR = 6'd4;

    // Decoded meaning of one register write
    typedef struct packed {
        logic data;
        logic base_hi;
        logic base_lo;
        logic size;
        logic pos;
        logic err_clr;
    } reg_hit_t;

    // One outgoing memory store
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } mem_req_t;
endpackage

// File: rtl/cbw_decode.sv
// Module: cbw_decode
// Turns a register index into one-hot hit flags. The data window is a run of
// NUM_DATA aliased indices starting at DATA_BASE; one comparator per alias.
// Assumes the data window does not overlap the configuration indices.
module cbw_decode
    import cbw_pkg::*;
#(
    parameter int IW        = IDX_W,
    parameter int DATA_BASE = 16,
    parameter int NUM_DATA  = 16
) (
    input  logic [IW-1:0] idx,
    output reg_hit_t      hit
);
    logic [NUM_DATA-1:0] alias_hit;

    // One equality compare per aliased data index
    for (genvar g = 0; g < NUM_DATA; g++) begin : g_alias
        localparam logic [IW-1:0] MATCH = IW'(DATA_BASE + g);
        assign alias_hit[g] = (idx == MATCH);
    end

    // Combine alias compares and decode the configuration indices
    always_comb begin
        hit         = '0;
        hit.data    = |alias_hit;
        hit.base_hi = (idx == IDX_BASE_HI);
        hit.base_lo = (idx == IDX_BASE_LO);
        hit.size    = (idx == IDX_SIZE);
        hit.pos     = (idx == IDX_POS);
        hit.err_clr = (idx == IDX_ERR_CLR);
    end
endmodule

// File: rtl/cbw_guard.sv
// Module: cbw_guard
// Decides whether a data word may be stored and forms its byte address.
// A word fits when position + one word does not exceed the size; the base
// must be non-zero. The position is zero-extended into the address sum.
module cbw_guard
    import cbw_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [WORD_W-1:0] size,
    input  logic [WORD_W-1:0] pos,
    output logic              ok,
    output logic [ADDR_W-1:0] addr
);
    localparam int SUM_W = WORD_W + 1;

    logic [SUM_W-1:0] pos_end;
    logic             fits;
    logic             base_set;

    // Bounds and base checks plus address formation
    always_comb begin
        pos_end  = {1'b0, pos} + SUM_W'(WORD_BYTES);
        fits     = (pos_end <= {1'b0, size});
        base_set = (base != '0);
        ok       = fits && base_set;
        addr     = base + ADDR_W'(pos);
    end
endmodule

// File: rtl/cbw_regs.sv
// Module: cbw_regs
// Holds the programmed base, size, write position and sticky error bit.
// Assumes at most one register write per cycle and that accept/reject are
// only raised together with a taken data write.
module cbw_regs
    import cbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  reg_hit_t          hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              accept,
    input  logic              reject,
    output logic [ADDR_W-1:0] base,
    output logic [WORD_W-1:0] size,
    output logic [WORD_W-1:0] pos,
    output logic              err
);
    localparam int HALF = ADDR_W / 2;

    // Base halves and size: loaded by configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            size <= '0;
        end else if (wr_take) begin
            if (hit.base_hi) base[ADDR_W-1:HALF] <= wdata[HALF-1:0];
            if (hit.base_lo) base[HALF-1:0]      <= wdata[HALF-1:0];
            if (hit.size)    size                <= wdata;
        end
    end

    // Write position: direct load or advance by one word per stored word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (wr_take && hit.pos) begin
            pos <= wdata;
        end else if (accept) begin
            pos <= pos + WORD_W'(WORD_BYTES);
        end
    end

    // Sticky error: set on refusal, cleared by writing 1 to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (reject) begin
            err <= 1'b1;
        end else if (wr_take && hit.err_clr && wdata[0]) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/cbw_req_stage.sv
// Module: cbw_req_stage
// Single-entry output register for memory stores. A new store may load in
// the same cycle the held one is taken. Exposes whether a load is possible.
module cbw_req_stage
    import cbw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  mem_req_t load_req,
    input  logic     out_ready,
    output logic     out_valid,
    output mem_req_t out_req,
    output logic     can_load
);
    // Space exists when empty or when the held store leaves this cycle
    assign can_load = !out_valid || out_ready;

    // Occupancy of the output entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Payload of the output entry, held while not taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_req <= '0;
        end else if (load) begin
            out_req <= load_req;
        end
    end
endmodule

// File: rtl/cbuf_stream_writer.sv
// Module: cbuf_stream_writer
// Top level: register write port in, memory store port out. Data-window
// writes become stores at base + position; configuration writes update the
// register file. All register writes wait while the output entry is blocked.
module cbuf_stream_writer
    import cbw_pkg::*;
#(
    parameter int DATA_BASE = 16,
    parameter int NUM_DATA  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_valid,
    output logic              reg_wr_ready,
    input  logic [IDX_W-1:0]  reg_wr_idx,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_data,
    output logic              err_flag
);
    reg_hit_t          hit;
    logic              wr_take;
    logic              data_hit;
    logic              clr_hit;
    logic              guard_ok;
    logic              accept;
    logic              reject;
    logic              can_load;
    logic [ADDR_W-1:0] cur_base;
    logic [WORD_W-1:0] cur_size;
    logic [WORD_W-1:0] cur_pos;
    logic [ADDR_W-1:0] word_addr;
    mem_req_t          new_req;
    mem_req_t          held_req;

    cbw_decode #(
        .IW       (IDX_W),
        .DATA_BASE(DATA_BASE),
        .NUM_DATA (NUM_DATA)
    ) u_dec (
        .idx(reg_wr_idx),
        .hit(hit)
    );

    cbw_guard u_guard (
        .base(cur_base),
        .size(cur_size),
        .pos (cur_pos),
        .ok  (guard_ok),
        .addr(word_addr)
    );

    // Handshake and classification of the current register write
    always_comb begin
        reg_wr_ready  = can_load;
        wr_take       = reg_wr_valid && can_load;
        data_hit      = hit.data;
        clr_hit       = hit.err_clr;
        accept        = wr_take && data_hit && guard_ok;
        reject        = wr_take && data_hit && !guard_ok;
        new_req.addr  = word_addr;
        new_req.data  = reg_wr_data;
    end

    cbw_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_take(wr_take),
        .hit    (hit),
        .wdata  (reg_wr_data),
        .accept (accept),
        .reject (reject),
        .base   (cur_base),
        .size   (cur_size),
        .pos    (cur_pos),
        .err    (err_flag)
    );

    cbw_req_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_req (new_req),
        .out_ready(mem_req_ready),
        .out_valid(mem_req_valid),
        .out_req  (held_req),
        .can_load (can_load)
    );

    // Present the held store on the memory port
    assign mem_req_addr = held_req.addr;
    assign mem_req_data = held_req.data;
endmodule

// File: rtl/cbw_checker.sv
// Module: cbw_checker
// Protocol and behaviour properties for cbuf_stream_writer, bound below.
module cbw_checker
    import cbw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_valid,
    input logic              reg_wr_ready,
    input logic [WORD_W-1:0] reg_wr_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [WORD_W-1:0] mem_req_data,
    input logic              err_flag,
    input logic              data_hit,
    input logic              clr_hit,
    input logic              guard_ok
);
    logic take;
    assign take = reg_wr_valid && reg_wr_ready;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)); // R8
    AST_BLOCK_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |-> !reg_wr_ready); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !(take && clr_hit && reg_wr_data[0]) |=> err_flag); // R9
    AST_CFG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        take && !data_hit |=> !mem_req_valid); // R10
    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        take && data_hit && !guard_ok |=> !mem_req_valid && err_flag); // R5
    AST_ACCEPT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        take && data_hit && guard_ok |=> mem_req_valid && mem_req_data == $past(reg_wr_data)); // R2
endmodule

bind cbuf_stream_writer cbw_checker u_cbw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_ready (reg_wr_ready),
    .reg_wr_data  (reg_wr_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_data (mem_req_data),
    .err_flag     (err_flag),
    .data_hit     (data_hit),
    .clr_hit      (clr_hit),
    .guard_ok     (guard_ok)
);

// File: tb/cbuf_stream_writer_bench.sv
// Bench: behavioural reference model compared against the ports every cycle.
module cbuf_stream_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_valid = 1'b0;
    logic        reg_wr_ready;
    logic [5:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic        err_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model state
    longint unsigned m_base = 0;
    longint unsigned m_size = 0;
    longint unsigned m_pos  = 0;
    bit              m_err  = 0;
    bit              m_pend = 0;
    longint unsigned m_addr = 0;
    longint unsigned m_data = 0;

    bit        rand_ready = 0;
    bit [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    cbuf_stream_writer u_cbuf_stream_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_valid (reg_wr_valid),
        .reg_wr_ready (reg_wr_ready),
        .reg_wr_idx   (reg_wr_idx),
        .reg_wr_data  (reg_wr_data),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_req_data (mem_req_data),
        .err_flag     (err_flag)
    );

    task automatic chk(input string label, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", label, act, exp);
        end
    endtask

    // Apply model effect of one register write taken at the coming edge
    task automatic model_write(input int idx, input longint unsigned d);
        if (idx >= 16 && idx <= 31) begin
            if (m_base == 0 || m_pos + 4 > m_size) m_err = 1;
            else begin
                m_pend = 1;
                m_addr = m_base + m_pos;
                m_data = d;
                m_pos  = (m_pos + 4) & 64'hFFFF_FFFF;
            end
        end else if (idx == 0) m_base = (m_base & 64'hFFFF_FFFF) | (d << 32);
        else if (idx == 1) m_base = (m_base & 64'hFFFF_FFFF_0000_0000) | d;
        else if (idx == 2) m_size = d;
        else if (idx == 3) m_pos = d;
        else if (idx == 4) begin
            if (d[0]) m_err = 0;
        end
    endtask

    // One clock: drive ready, predict the edge, then compare all outputs
    task automatic step(output bit fired);
        bit mr;
        bit exp_rdy;
        mr = rand_ready ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready = mr;
        #1;
        exp_rdy = !m_pend || mr;
        chk("R8 reg_wr_ready", {63'd0, reg_wr_ready}, {63'd0, exp_rdy});
        fired = reg_wr_valid && exp_rdy;
        if (m_pend && mr) m_pend = 0;
        if (fired) model_write(int'(reg_wr_idx), longint'(reg_wr_data));
        @(negedge clk);
        chk("R10 mem_req_valid", {63'd0, mem_req_valid}, {63'd0, m_pend});
        if (m_pend) begin
            chk("R3 mem_req_addr", mem_req_addr, m_addr);
            chk("R2 mem_req_data", {32'd0, mem_req_data}, m_data);
        end
        chk("R9 err_flag", {63'd0, err_flag}, {63'd0, m_err});
    endtask

    task automatic do_wr(input int idx, input logic [31:0] d);
        bit f;
        reg_wr_valid = 1'b1;
        reg_wr_idx   = 6'(idx);
        reg_wr_data  = d;
        f = 0;
        while (!f) step(f);
        reg_wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        bit f;
        for (int i = 0; i < n; i++) step(f);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid after reset", {63'd0, mem_req_valid}, 64'd0);
        chk("R1 err after reset", {63'd0, err_flag}, 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R6: base still zero (R1 zero base), word refused
        do_wr(16, 32'hAAAA_0001);
        chk("R6 err on zero base", {63'd0, err_flag}, 64'd1);
        chk("R6 no request", {63'd0, mem_req_valid}, 64'd0);

        // R9: writing 0 keeps error, writing 1 clears
        do_wr(4, 32'h0);
        chk("R9 err kept by 0", {63'd0, err_flag}, 64'd1);
        do_wr(4, 32'h1);
        chk("R9 err cleared by 1", {63'd0, err_flag}, 64'd0);

        // Program base and a 16-byte size
        do_wr(0, 32'h0000_0001);
        do_wr(1, 32'h2000_0000);
        do_wr(2, 32'h10);
        chk("R10 no request after config", {63'd0, mem_req_valid}, 64'd0);

        do_wr(16, 32'h1111_0000);
        chk("R3 first address", mem_req_addr, 64'h1_2000_0000);
        do_wr(17, 32'h1111_0001);
        chk("R4 second address", mem_req_addr, 64'h1_2000_0004);
        do_wr(31, 32'h1111_0002);
        chk("R2 alias 31 data", {32'd0, mem_req_data}, 64'h1111_0002);
        do_wr(24, 32'h1111_0003);
        chk("R5 exact fit accepted", mem_req_addr, 64'h1_2000_000C);
        do_wr(20, 32'h1111_0004);
        chk("R5 overflow refused", {63'd0, mem_req_valid}, 64'd0);
        chk("R5 overflow flagged", {63'd0, err_flag}, 64'd1);
        do_wr(4, 32'h1);

        // R7: direct position load
        do_wr(3, 32'h4);
        do_wr(21, 32'h2222_0000);
        chk("R7 loaded position used", mem_req_addr, 64'h1_2000_0004);
        do_wr(5, 32'h5);
        chk("R10 unmapped index no request", {63'd0, mem_req_valid}, 64'd0);

        // Back-pressure: every alias, config writes interleaved (R8)
        rand_ready = 1;
        do_wr(2, 32'h100);
        do_wr(3, 32'h0);
        for (int i = 0; i < 16; i++) begin
            do_wr(16 + i, 32'h3000_0000 + 32'(i));
            if (i == 7) do_wr(1, 32'h4000_0000);
        end
        do_wr(2, 32'h48);
        for (int i = 0; i < 12; i++) do_wr(16 + (i % 16), 32'h5000_0000 + 32'(i));
        do_wr(4, 32'h1);
        do_wr(0, 32'h0);
        do_wr(1, 32'h0);
        do_wr(18, 32'h6);
        idle(8);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule